// File: doc/BRIEF.md
# Dual-Bus Modulo Address Generator

This block computes addresses for a DSP core that moves data over two independent data buses, called X and Y, in the same instruction. For each bus it picks a pointer from a small subset of the general registers g0..g9. It issues that pointer as the bus address and, if asked, computes the post-updated pointer value for register write-back. The memories and the data-register file sit outside the block. The register values arrive as a flat input bus, and the write-back leaves as one valid/index/value triple per bus.

The post-update adds the access size (2 bytes for a word, 4 for a long) or an index register (g8 for X, g9 for Y). On the X bus a modulo mode can replace that step. When modulo is enabled and the low 16 bits of the pointer equal a programmed end value, a programmed delta is added instead, which wraps a circular buffer. A 4-bit selector field from the instruction chooses, per bus, between the normal pointer pair and a wider alternate map. Both buses are computed in parallel in one cycle, and every result is registered.

Top module: `dual_bus_agu`

## Requirements
- R1: With the alternate map off, the X pointer is g5 when x_field bit 1 is 1 and g4 otherwise. The Y pointer is g7 when y_field bit 0 is 1 and g6 otherwise.
- R2: The alternate X map is used when op_sel[1:0] is nonzero. In it, x_field values 0, 1, 2, 3 select g4, g0, g5, g1.
- R3: The alternate Y map is used when op_sel[3:2] is nonzero, independently of X. In it, y_field values 0, 1, 2, 3 select g6, g7, g2, g3.
- R4: A request on req_valid gives, one clock later, the selected pointer's value before update on x_addr and y_addr, with both address valids high.
- R5: Mode code 1 (size step) writes back pointer+2 when the long flag is 0 and pointer+4 when it is 1.
- R6: Mode code 2 (index step) writes back pointer+g8 on X and pointer+g9 on Y.
- R7: Mode codes 0 and 3 issue the address but raise no write-back.
- R8: On X, when mod_en is 1 and bits 15:0 of the pointer equal mod_end, the write-back value is pointer+mod_delta for both step modes. The upper pointer bits are not compared.
- R9: With mod_en at 0 the normal step is always used, and the Y bus never applies the modulo substitution.
- R10: The write-back is a one-cycle valid with a 4-bit register index (the number n of gn) and the 32-bit updated value, one triple per bus.
- R11: Reset clears all valids, and a cycle without req_valid produces no valid on any output one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request this cycle |
| op_sel | input | 4 | Map selector; [1:0] for X, [3:2] for Y |
| x_field | input | 2 | X pointer field |
| x_mode | input | 2 | X update mode: 0 none, 1 size, 2 index, 3 none |
| x_long | input | 1 | X access is 32-bit |
| y_field | input | 2 | Y pointer field |
| y_mode | input | 2 | Y update mode, same coding as X |
| y_long | input | 1 | Y access is 32-bit |
| mod_en | input | 1 | Enable X modulo wrap |
| mod_end | input | 16 | Modulo end value for pointer bits 15:0 |
| mod_delta | input | 32 | Value added on a modulo hit |
| gpr_flat | input | 320 | g0..g9, gn at bits 32n+31:32n |
| x_addr_valid | output | 1 | X address valid |
| x_addr | output | 32 | X bus address |
| y_addr_valid | output | 1 | Y address valid |
| y_addr | output | 32 | Y bus address |
| x_wb_valid | output | 1 | X pointer write-back valid |
| x_wb_idx | output | 4 | X pointer register number |
| x_wb_value | output | 32 | X updated pointer |
| y_wb_valid | output | 1 | Y pointer write-back valid |
| y_wb_idx | output | 4 | Y pointer register number |
| y_wb_value | output | 32 | Y updated pointer |

## Verification
The assertions assume the register file holds at least ten entries and that mode, field and map inputs are stable for the whole request cycle. The modulo check also assumes mod_delta does not change between a request and its registered result. The stimulus drives every input on the falling edge and holds it across the rising edge. It changes mod_end, mod_delta and the register values only between requests, never inside one, so the sampled pointer and settings always belong to a single transfer.

// File: rtl/dbagu_pkg.sv
package dbagu_pkg;

    localparam int IDX_W = 4;

    typedef enum logic [1:0] {
        UPD_NONE  = 2'd0,
        UPD_SIZE  = 2'd1,
        UPD_INDEX = 2'd2,
        UPD_RSVD  = 2'd3
    } upd_mode_e;

    typedef struct packed {
        logic [1:0] field;
        upd_mode_e  mode;
        logic       is_long;
    } lane_req_t;

    // Register number for the pointer of one bus.
    function automatic logic [IDX_W-1:0] ptr_index(input logic is_x,
                                                   input logic alt,
                                                   input logic [1:0] f);
        logic [IDX_W-1:0] r;
        if (is_x) begin
            if (alt) begin
                case (f)
                    2'd0:    r = 4'd4;
                    2'd1:    r = 4'd0;
                    2'd2:    r = 4'd5;
                    default: r = 4'd1;
                endcase
            end else begin
                r = f[1] ? 4'd5 : 4'd4;
            end
        end else begin
            if (alt) begin
                case (f)
                    2'd0:    r = 4'd6;
                    2'd1:    r = 4'd7;
                    2'd2:    r = 4'd2;
                    default: r = 4'd3;
                endcase
            end else begin
                r = f[0] ? 4'd7 : 4'd6;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/dbagu_ptr_sel.sv
module dbagu_ptr_sel
    import dbagu_pkg::*;
#(
    parameter bit IS_X = 1'b1,
    parameter int NREG = 10,
    parameter int DW   = 32
) (
    input  logic               alt,
    input  logic [1:0]         field,
    input  logic [NREG*DW-1:0] regs,
    output logic [IDX_W-1:0]   idx,
    output logic [DW-1:0]      ptr
);
    always_comb begin
        idx = ptr_index(IS_X, alt, field);
        ptr = regs[idx*DW +: DW];
    end
endmodule

// File: rtl/dbagu_step.sv
module dbagu_step
    import dbagu_pkg::*;
#(
    parameter int DW      = 32,
    parameter int MW      = 16,
    parameter bit USE_MOD = 1'b1
) (
    input  lane_req_t       req,
    input  logic [DW-1:0]   ptr,
    input  logic [DW-1:0]   idx_val,
    input  logic            mod_en,
    input  logic [MW-1:0]   mod_end,
    input  logic [DW-1:0]   mod_delta,
    output logic            upd,
    output logic            hit,
    output logic [DW-1:0]   nxt
);
    localparam logic [DW-1:0] STEP_WORD = DW'(2);
    localparam logic [DW-1:0] STEP_LONG = DW'(4);

    logic [DW-1:0] step;

    always_comb begin
        upd  = (req.mode == UPD_SIZE) || (req.mode == UPD_INDEX);
        hit  = USE_MOD && mod_en && (ptr[MW-1:0] == mod_end);
        step = (req.mode == UPD_INDEX) ? idx_val
             : (req.is_long ? STEP_LONG : STEP_WORD);
        nxt  = ptr + (hit ? mod_delta : step);
    end
endmodule

// File: rtl/dbagu_lane.sv
module dbagu_lane
    import dbagu_pkg::*;
#(
    parameter bit IS_X = 1'b1,
    parameter int NREG = 10,
    parameter int DW   = 32,
    parameter int MW   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_in,
    input  logic               alt,
    input  lane_req_t          req,
    input  logic [NREG*DW-1:0] regs,
    input  logic               mod_en,
    input  logic [MW-1:0]      mod_end,
    input  logic [DW-1:0]      mod_delta,
    output logic               addr_valid,
    output logic [DW-1:0]      addr,
    output logic               wb_valid,
    output logic [IDX_W-1:0]   wb_idx,
    output logic [DW-1:0]      wb_value
);
    localparam int IDX_REG = IS_X ? 8 : 9;

    logic [IDX_W-1:0] sel_idx;
    logic [DW-1:0]    sel_ptr;
    logic             upd, hit;
    logic [DW-1:0]    nxt;

    dbagu_ptr_sel #(.IS_X(IS_X), .NREG(NREG), .DW(DW)) u_sel (
        .alt(alt), .field(req.field), .regs(regs),
        .idx(sel_idx), .ptr(sel_ptr)
    );

    dbagu_step #(.DW(DW), .MW(MW), .USE_MOD(IS_X)) u_step (
        .req(req), .ptr(sel_ptr), .idx_val(regs[IDX_REG*DW +: DW]),
        .mod_en(mod_en), .mod_end(mod_end), .mod_delta(mod_delta),
        .upd(upd), .hit(hit), .nxt(nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_valid <= 1'b0;
            addr       <= '0;
            wb_valid   <= 1'b0;
            wb_idx     <= '0;
            wb_value   <= '0;
        end else begin
            addr_valid <= valid_in;
            addr       <= sel_ptr;
            wb_valid   <= valid_in && upd;
            wb_idx     <= sel_idx;
            wb_value   <= nxt;
        end
    end

    // R10: a write-back always belongs to an issued transfer
    assert_wb_has_xfer_R10: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> addr_valid);

    // R11: nothing comes out without a request
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(valid_in) |-> (!addr_valid && !wb_valid));

    // R5: size step without modulo moves the pointer by 2 or 4
    assert_size_step_R5: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && $past(valid_in && req.mode == UPD_SIZE && !hit))
        |-> (wb_value - addr) == ($past(req.is_long) ? DW'(4) : DW'(2)));

    generate
        if (IS_X) begin : g_x_chk
            // R2: X write-back only targets the X pointer set
            assert_x_ptr_set_R2: assert property (@(posedge clk) disable iff (rst)
                wb_valid |-> (wb_idx inside {4'd0, 4'd1, 4'd4, 4'd5}));
            // R8: a modulo hit adds the programmed delta
            assert_mod_wrap_R8: assert property (@(posedge clk) disable iff (rst)
                (wb_valid && $past(valid_in && hit))
                |-> wb_value == addr + $past(mod_delta));
        end else begin : g_y_chk
            // R3: Y write-back only targets the Y pointer set
            assert_y_ptr_set_R3: assert property (@(posedge clk) disable iff (rst)
                wb_valid |-> (wb_idx inside {4'd2, 4'd3, 4'd6, 4'd7}));
        end
    endgenerate
endmodule

// File: rtl/dual_bus_agu.sv
module dual_bus_agu
    import dbagu_pkg::*;
#(
    parameter int NREG = 10,
    parameter int DW   = 32,
    parameter int MW   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [3:0]         op_sel,
    input  logic [1:0]         x_field,
    input  logic [1:0]         x_mode,
    input  logic               x_long,
    input  logic [1:0]         y_field,
    input  logic [1:0]         y_mode,
    input  logic               y_long,
    input  logic               mod_en,
    input  logic [MW-1:0]      mod_end,
    input  logic [DW-1:0]      mod_delta,
    input  logic [NREG*DW-1:0] gpr_flat,
    output logic               x_addr_valid,
    output logic [DW-1:0]      x_addr,
    output logic               y_addr_valid,
    output logic [DW-1:0]      y_addr,
    output logic               x_wb_valid,
    output logic [IDX_W-1:0]   x_wb_idx,
    output logic [DW-1:0]      x_wb_value,
    output logic               y_wb_valid,
    output logic [IDX_W-1:0]   y_wb_idx,
    output logic [DW-1:0]      y_wb_value
);
    localparam int NLANE = 2;

    lane_req_t        req_a   [NLANE];
    logic             alt_a   [NLANE];
    logic             av_a    [NLANE];
    logic [DW-1:0]    ad_a    [NLANE];
    logic             wv_a    [NLANE];
    logic [IDX_W-1:0] wi_a    [NLANE];
    logic [DW-1:0]    wd_a    [NLANE];

    always_comb begin
        req_a[0] = '{field: x_field, mode: upd_mode_e'(x_mode), is_long: x_long};
        req_a[1] = '{field: y_field, mode: upd_mode_e'(y_mode), is_long: y_long};
        alt_a[0] = |op_sel[1:0];
        alt_a[1] = |op_sel[3:2];
    end

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane
            dbagu_lane #(.IS_X(g == 0), .NREG(NREG), .DW(DW), .MW(MW)) u_lane (
                .clk(clk), .rst(rst), .valid_in(req_valid),
                .alt(alt_a[g]), .req(req_a[g]), .regs(gpr_flat),
                .mod_en(mod_en), .mod_end(mod_end), .mod_delta(mod_delta),
                .addr_valid(av_a[g]), .addr(ad_a[g]),
                .wb_valid(wv_a[g]), .wb_idx(wi_a[g]), .wb_value(wd_a[g])
            );
        end
    endgenerate

    assign x_addr_valid = av_a[0];
    assign x_addr       = ad_a[0];
    assign x_wb_valid   = wv_a[0];
    assign x_wb_idx     = wi_a[0];
    assign x_wb_value   = wd_a[0];
    assign y_addr_valid = av_a[1];
    assign y_addr       = ad_a[1];
    assign y_wb_valid   = wv_a[1];
    assign y_wb_idx     = wi_a[1];
    assign y_wb_value   = wd_a[1];
endmodule

// File: tb/dual_bus_agu_test.sv
module dual_bus_agu_test;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [3:0] op_sel = '0;
    logic [1:0] x_field = '0, x_mode = '0, y_field = '0, y_mode = '0;
    logic x_long = 1'b0, y_long = 1'b0;
    logic mod_en = 1'b0;
    logic [15:0] mod_end = 16'hFFFF;
    logic [31:0] mod_delta = 32'hFFFF_F800;
    logic [31:0] regs_b [NREG];
    logic [NREG*32-1:0] gpr_flat;
    logic x_addr_valid, y_addr_valid, x_wb_valid, y_wb_valid;
    logic [31:0] x_addr, y_addr, x_wb_value, y_wb_value;
    logic [3:0] x_wb_idx, y_wb_idx;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb
        for (int k = 0; k < NREG; k++) gpr_flat[k*32 +: 32] = regs_b[k];

    dual_bus_agu uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .op_sel(op_sel),
        .x_field(x_field), .x_mode(x_mode), .x_long(x_long),
        .y_field(y_field), .y_mode(y_mode), .y_long(y_long),
        .mod_en(mod_en), .mod_end(mod_end), .mod_delta(mod_delta),
        .gpr_flat(gpr_flat),
        .x_addr_valid(x_addr_valid), .x_addr(x_addr),
        .y_addr_valid(y_addr_valid), .y_addr(y_addr),
        .x_wb_valid(x_wb_valid), .x_wb_idx(x_wb_idx), .x_wb_value(x_wb_value),
        .y_wb_valid(y_wb_valid), .y_wb_idx(y_wb_idx), .y_wb_value(y_wb_value)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  xf, xm; logic xl;
        logic [1:0]  yf, ym; logic yl;
        logic [31:0] xa; logic xwv; logic [3:0] xi; logic [31:0] xv;
        logic [31:0] ya; logic ywv; logic [3:0] yi; logic [31:0] yv;
    } vec_t;

    // gk = 0x1000*(k+1) for k<8, g8 = 0x40, g9 = 0x80; mod_end never matches
    localparam vec_t VECS [9] = '{
        '{4'h0, 2'd0, 2'd1, 1'b0, 2'd0, 2'd1, 1'b1, 32'h5000, 1'b1, 4'd4, 32'h5002, 32'h7000, 1'b1, 4'd6, 32'h7004},
        '{4'h0, 2'd2, 2'd2, 1'b0, 2'd1, 2'd2, 1'b0, 32'h6000, 1'b1, 4'd5, 32'h6040, 32'h8000, 1'b1, 4'd7, 32'h8080},
        '{4'h0, 2'd1, 2'd0, 1'b0, 2'd2, 2'd0, 1'b0, 32'h5000, 1'b0, 4'd0, 32'h0,    32'h7000, 1'b0, 4'd0, 32'h0},
        '{4'h1, 2'd1, 2'd1, 1'b1, 2'd3, 2'd1, 1'b0, 32'h1000, 1'b1, 4'd0, 32'h1004, 32'h8000, 1'b1, 4'd7, 32'h8002},
        '{4'h4, 2'd3, 2'd1, 1'b0, 2'd2, 2'd2, 1'b0, 32'h6000, 1'b1, 4'd5, 32'h6002, 32'h3000, 1'b1, 4'd2, 32'h3080},
        '{4'hF, 2'd2, 2'd1, 1'b1, 2'd3, 2'd1, 1'b1, 32'h6000, 1'b1, 4'd5, 32'h6004, 32'h4000, 1'b1, 4'd3, 32'h4004},
        '{4'h2, 2'd3, 2'd2, 1'b0, 2'd0, 2'd3, 1'b0, 32'h2000, 1'b1, 4'd1, 32'h2040, 32'h7000, 1'b0, 4'd0, 32'h0},
        '{4'h8, 2'd0, 2'd0, 1'b0, 2'd1, 2'd1, 1'b0, 32'h5000, 1'b0, 4'd0, 32'h0,    32'h8000, 1'b1, 4'd7, 32'h8002},
        '{4'h3, 2'd0, 2'd1, 1'b0, 2'd0, 2'd0, 1'b0, 32'h5000, 1'b1, 4'd4, 32'h5002, 32'h7000, 1'b0, 4'd0, 32'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [1:0] xf, input logic [1:0] xm,
                         input logic xl, input logic [1:0] yf, input logic [1:0] ym,
                         input logic yl);
        @(negedge clk);
        req_valid = 1'b1; op_sel = op;
        x_field = xf; x_mode = xm; x_long = xl;
        y_field = yf; y_mode = ym; y_long = yl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++; n_checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) regs_b[k] = 32'h1000 * (k + 1);
        regs_b[8] = 32'h40;
        regs_b[9] = 32'h80;
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset holds all valids low even with a request present
        chk("R11 reset x_addr_valid", 32'(x_addr_valid), 32'd0);
        chk("R11 reset y_addr_valid", 32'(y_addr_valid), 32'd0);
        chk("R11 reset wb valids", 32'({x_wb_valid, y_wb_valid}), 32'd0);
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        // R11: idle cycle
        chk("R11 idle valids", 32'({x_addr_valid, y_addr_valid, x_wb_valid, y_wb_valid}), 32'd0);

        mod_en = 1'b1;
        for (int i = 0; i < 9; i++) begin
            vec_t v;
            v = VECS[i];
            issue(v.op, v.xf, v.xm, v.xl, v.yf, v.ym, v.yl);
            // R1 R2 R3 R4: address; R5 R6 R7 R10: write-back
            chk($sformatf("R4 vec%0d x_addr_valid", i), 32'(x_addr_valid), 32'd1);
            chk($sformatf("R4 vec%0d y_addr_valid", i), 32'(y_addr_valid), 32'd1);
            chk($sformatf("R1/R2 vec%0d x_addr", i), x_addr, v.xa);
            chk($sformatf("R1/R3 vec%0d y_addr", i), y_addr, v.ya);
            chk($sformatf("R7 vec%0d x_wb_valid", i), 32'(x_wb_valid), 32'(v.xwv));
            chk($sformatf("R7 vec%0d y_wb_valid", i), 32'(y_wb_valid), 32'(v.ywv));
            if (v.xwv) begin
                chk($sformatf("R10 vec%0d x_wb_idx", i), 32'(x_wb_idx), 32'(v.xi));
                chk($sformatf("R5/R6 vec%0d x_wb_value", i), x_wb_value, v.xv);
            end
            if (v.ywv) begin
                chk($sformatf("R10 vec%0d y_wb_idx", i), 32'(y_wb_idx), 32'(v.yi));
                chk($sformatf("R5/R6 vec%0d y_wb_value", i), y_wb_value, v.yv);
            end
        end

        // R10: write-back lasts a single cycle
        @(negedge clk);
        chk("R10 wb drops after one cycle", 32'({x_wb_valid, y_wb_valid}), 32'd0);

        // R8: modulo hit on size step
        mod_end = 16'h5000;
        issue(4'h0, 2'd0, 2'd1, 1'b0, 2'd0, 2'd0, 1'b0);
        chk("R8 mod size x_wb_value", x_wb_value, 32'h4800);
        // R8: modulo hit on index step
        issue(4'h0, 2'd0, 2'd2, 1'b0, 2'd0, 2'd0, 1'b0);
        chk("R8 mod index x_wb_value", x_wb_value, 32'h4800);
        // R9: disabled modulo uses the normal step
        mod_en = 1'b0;
        issue(4'h0, 2'd0, 2'd1, 1'b0, 2'd0, 2'd0, 1'b0);
        chk("R9 mod off x_wb_value", x_wb_value, 32'h5002);
        // R8: only low 16 bits compared
        mod_en = 1'b1;
        regs_b[4] = 32'h0001_5000;
        issue(4'h0, 2'd0, 2'd1, 1'b1, 2'd0, 2'd0, 1'b0);
        chk("R8 low16 x_addr", x_addr, 32'h0001_5000);
        chk("R8 low16 x_wb_value", x_wb_value, 32'h0001_4800);
        // R9: Y bus ignores modulo
        mod_end = 16'h7000;
        issue(4'h0, 2'd0, 2'd0, 1'b0, 2'd0, 2'd1, 1'b0);
        chk("R9 y no modulo y_wb_value", y_wb_value, 32'h7002);
        chk("R9 y no modulo x_wb_valid", 32'(x_wb_valid), 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule